// File: doc/BRIEF.md
# Speculative Branch Checkpoint Tracker

This block keeps one recovery checkpoint for every unresolved predicted branch in an out-of-order core, so that a misprediction can be undone in a single cycle. When the front end predicts a branch, it asks for an entry. The block returns a one-hot branch tag and stores everything needed to resume on the correct path. That state is the recovery PC and a set of opaque snapshots: the rename map, the free list, the predictor history, and the reorder-buffer and load/store-queue tail pointers. The block never interprets these snapshot bits.

The block also exports the mask of branches that are still unresolved. Each dispatching instruction copies that mask as its dependency mask. When a branch resolves, the block broadcasts its tag in the same cycle with one of two meanings:

- **Clear:** the prediction was correct. Every holder removes that bit, and the entry is freed.
- **Squash:** the prediction was wrong. Every holder with that bit set is discarded. The stored checkpoint appears on the recovery outputs, and the entry is released together with every entry allocated after it.

A new branch may be allocated in the very next cycle.

Top module: `branch_ckpt_stack`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `live_mask` is all zeros, `alloc_full` is low, and `bc_clear` and `bc_squash` are low.
- R2: When `alloc_req` is high, `alloc_full` is low and no squash happens in that cycle, `alloc_grant` is high. `alloc_tag` then has exactly one bit set: the bit of the lowest-index entry that is clear in `live_mask`. That bit is set in `live_mask` after the clock edge. Without a grant, `alloc_tag` is zero.
- R3: `alloc_full` is high exactly when every bit of `live_mask` is set. While it is high, no grant is given and `live_mask` gains no bit.
- R4: `alloc_dep_mask` equals `live_mask` with the bit of a same-cycle correct resolve removed. This is the dependency mask stored for the allocating branch.
- R5: A correct resolve (`rslv_valid` high, `rslv_mispred` low, `rslv_tag` one-hot and live) raises `bc_clear` with `bc_tag` equal to `rslv_tag` in the same cycle. After the edge, only that bit is removed from `live_mask`.
- R6: A mispredicted resolve of a live one-hot tag raises `bc_squash` with `bc_tag` equal to `rslv_tag` in the same cycle. After the edge, `live_mask` holds only those branches that were older than the squashed one and are still unresolved.
- R7: In a squash cycle, `rec_map`, `rec_fl`, `rec_bp`, `rec_rob_tail` and `rec_lsq_tail` equal the values captured when that branch was allocated.
- R8: In a squash cycle, `rec_pc` is `alloc_pc + INSN_BYTES` if the branch was allocated with `alloc_pred_taken` high, and `alloc_target` if it was allocated with `alloc_pred_taken` low.
- R9: An allocation request in a squash cycle is dropped: `alloc_grant` is low and no new entry becomes live.
- R10: A resolve is ignored if its tag is not one-hot or names an entry that is not live. In that case no broadcast is raised and `live_mask` keeps its value, apart from any same-cycle allocation.
- R11: An entry freed by a resolve can be granted again in the next cycle, and an allocation is granted in the cycle right after a squash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronous to clk |
| alloc_req | input | 1 | A predicted branch asks for a checkpoint |
| alloc_pred_taken | input | 1 | Predicted direction of that branch |
| alloc_pc | input | PC_W | Address of the branch |
| alloc_target | input | PC_W | Computed branch target |
| alloc_map_snap | input | MAP_W | Rename-map snapshot |
| alloc_fl_snap | input | FL_W | Free-list snapshot |
| alloc_bp_snap | input | BP_W | Predictor history repair state |
| alloc_rob_tail | input | ROB_W | Reorder-buffer tail pointer |
| alloc_lsq_tail | input | LSQ_W | Load/store-queue tail pointer |
| alloc_full | output | 1 | No entry is free; branch dispatch must stall |
| alloc_grant | output | 1 | Allocation accepted this cycle |
| alloc_tag | output | NUM_CKPT | One-hot tag of the granted entry |
| alloc_dep_mask | output | NUM_CKPT | Dependency mask for the allocating branch |
| live_mask | output | NUM_CKPT | Unresolved branches; copied by each dispatching instruction |
| rslv_valid | input | 1 | A branch resolves this cycle |
| rslv_tag | input | NUM_CKPT | One-hot tag of the resolving branch |
| rslv_mispred | input | 1 | The resolving branch was mispredicted |
| bc_clear | output | 1 | Broadcast: remove bc_tag from all masks |
| bc_squash | output | 1 | Broadcast: kill holders of bc_tag |
| bc_tag | output | NUM_CKPT | Tag being broadcast, zero otherwise |
| rec_pc | output | PC_W | Fetch restart address |
| rec_map | output | MAP_W | Rename-map snapshot to restore |
| rec_fl | output | FL_W | Free-list snapshot to restore |
| rec_bp | output | BP_W | Predictor state to restore |
| rec_rob_tail | output | ROB_W | Reorder-buffer tail to restore |
| rec_lsq_tail | output | LSQ_W | Load/store-queue tail to restore |

## Verification
The bench builds the block with its default parameters: four entries, 32-bit addresses, 64-bit map and free-list snapshots, 16-bit predictor state, and 6-bit and 5-bit tail pointers. Four entries are few enough that a handful of branches fill the table. This puts the full-stall path, reuse of a freed entry while other entries are still live, and out-of-order reuse of indices within reach of short directed sequences. Because indices are reused out of order, a squash must remove younger entries that sit at lower indices than the squashed one. The wide snapshot fields make a swapped or truncated payload slice show up on the recovery outputs. A long randomized phase then mixes allocations, clears, squashes and bogus tags in the same cycles, and compares every output against an age-ordered list model.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  // Outcome of the resolve port in one cycle
  typedef enum logic [1:0] {
    RSV_IDLE   = 2'd0,
    RSV_CLEAR  = 2'd1,
    RSV_SQUASH = 2'd2
  } rsv_kind_e;

  // A resolve only acts when it names exactly one live entry
  function automatic rsv_kind_e rsv_classify(input logic vld,
                                             input logic mispred,
                                             input logic names_live);
    rsv_kind_e k;
    if (!(vld && names_live)) k = RSV_IDLE;
    else if (mispred)         k = RSV_SQUASH;
    else                      k = RSV_CLEAR;
    return k;
  endfunction

endpackage

// File: rtl/bcs_alloc.sv
// Picks the lowest-index free entry and decides whether it is granted.
module bcs_alloc #(
  parameter int NUM_CKPT = 4
) (
  input  logic [NUM_CKPT-1:0] live,
  input  logic                req,
  input  logic                block,
  output logic                full,
  output logic                grant,
  output logic [NUM_CKPT-1:0] tag
);

  logic [NUM_CKPT-1:0] pick;
  logic                found;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_CKPT; i++) begin
      if (!found && !live[i]) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  assign full  = &live;
  assign grant = req && !full && !block;
  assign tag   = grant ? pick : '0;

endmodule

// File: rtl/bcs_entry.sv
// One checkpoint slot: opaque payload plus the mask of older live branches.
module bcs_entry #(
  parameter int NUM_CKPT = 4,
  parameter int PAY_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [PAY_W-1:0]    wr_payload,
  input  logic [NUM_CKPT-1:0] wr_parent,
  input  logic                clr_en,
  input  logic [NUM_CKPT-1:0] clr_mask,
  output logic [PAY_W-1:0]    rd_payload,
  output logic [NUM_CKPT-1:0] rd_parent
);

  logic [PAY_W-1:0]    payload_q;
  logic [NUM_CKPT-1:0] parent_q;
  logic [NUM_CKPT-1:0] parent_d;
  logic                parent_en;

  // Next state of the older-branch mask
  always_comb begin
    parent_d = parent_q;
    if (clr_en) parent_d = parent_q & ~clr_mask;
    if (wr_en)  parent_d = wr_parent;
  end

  assign parent_en = wr_en | clr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         parent_q <= '0;
    else if (parent_en) parent_q <= parent_d;
  end

  // Datapath storage, written only on allocation
  always_ff @(posedge clk) begin
    if (wr_en) payload_q <= wr_payload;
  end

  assign rd_payload = payload_q;
  assign rd_parent  = parent_q;

endmodule

// File: rtl/bcs_rd_mux.sv
// One-hot AND-OR selector over a flat array of equal-width words.
module bcs_rd_mux #(
  parameter int NUM_CKPT = 4,
  parameter int W        = 8
) (
  input  logic [NUM_CKPT-1:0]   sel,
  input  logic [NUM_CKPT*W-1:0] words,
  output logic [W-1:0]          dout
);

  always_comb begin
    dout = '0;
    for (int i = 0; i < NUM_CKPT; i++) begin
      if (sel[i]) dout = dout | words[i*W +: W];
    end
  end

endmodule

// File: rtl/branch_ckpt_stack.sv
module branch_ckpt_stack
  import bcs_pkg::*;
#(
  parameter int NUM_CKPT   = 4,
  parameter int PC_W       = 32,
  parameter int MAP_W      = 64,
  parameter int FL_W       = 64,
  parameter int BP_W       = 16,
  parameter int ROB_W      = 6,
  parameter int LSQ_W      = 5,
  parameter int INSN_BYTES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc_req,
  input  logic                alloc_pred_taken,
  input  logic [PC_W-1:0]     alloc_pc,
  input  logic [PC_W-1:0]     alloc_target,
  input  logic [MAP_W-1:0]    alloc_map_snap,
  input  logic [FL_W-1:0]     alloc_fl_snap,
  input  logic [BP_W-1:0]     alloc_bp_snap,
  input  logic [ROB_W-1:0]    alloc_rob_tail,
  input  logic [LSQ_W-1:0]    alloc_lsq_tail,
  output logic                alloc_full,
  output logic                alloc_grant,
  output logic [NUM_CKPT-1:0] alloc_tag,
  output logic [NUM_CKPT-1:0] alloc_dep_mask,
  output logic [NUM_CKPT-1:0] live_mask,
  input  logic                rslv_valid,
  input  logic [NUM_CKPT-1:0] rslv_tag,
  input  logic                rslv_mispred,
  output logic                bc_clear,
  output logic                bc_squash,
  output logic [NUM_CKPT-1:0] bc_tag,
  output logic [PC_W-1:0]     rec_pc,
  output logic [MAP_W-1:0]    rec_map,
  output logic [FL_W-1:0]     rec_fl,
  output logic [BP_W-1:0]     rec_bp,
  output logic [ROB_W-1:0]    rec_rob_tail,
  output logic [LSQ_W-1:0]    rec_lsq_tail
);

  // Payload layout: {pc, map, freelist, predictor, rob tail, lsq tail}
  localparam int LSQ_LO = 0;
  localparam int ROB_LO = LSQ_LO + LSQ_W;
  localparam int BP_LO  = ROB_LO + ROB_W;
  localparam int FL_LO  = BP_LO + BP_W;
  localparam int MAP_LO = FL_LO + FL_W;
  localparam int PC_LO  = MAP_LO + MAP_W;
  localparam int PAY_W  = PC_LO + PC_W;

  logic [NUM_CKPT-1:0] live_q;
  logic [NUM_CKPT-1:0] live_d;
  logic                live_en;

  // ---------------- resolve decode ----------------
  logic                tag_onehot;
  logic                tag_live;
  rsv_kind_e           rsv_kind;
  logic                do_squash;
  logic [NUM_CKPT-1:0] clr_mask;
  logic [NUM_CKPT-1:0] rd_sel;

  assign tag_onehot = (rslv_tag != '0) && ((rslv_tag & (rslv_tag - 1'b1)) == '0);
  assign tag_live   = tag_onehot && ((rslv_tag & live_q) != '0);
  assign rsv_kind   = rsv_classify(rslv_valid, rslv_mispred, tag_live);
  assign do_squash  = (rsv_kind == RSV_SQUASH);
  assign clr_mask   = (rsv_kind == RSV_CLEAR) ? rslv_tag : '0;
  assign rd_sel     = do_squash ? rslv_tag : '0;

  assign bc_clear   = (rsv_kind == RSV_CLEAR);
  assign bc_squash  = do_squash;
  assign bc_tag     = (rsv_kind != RSV_IDLE) ? rslv_tag : '0;

  // ---------------- allocation ----------------
  bcs_alloc #(
    .NUM_CKPT (NUM_CKPT)
  ) alloc_i (
    .live  (live_q),
    .req   (alloc_req),
    .block (do_squash),
    .full  (alloc_full),
    .grant (alloc_grant),
    .tag   (alloc_tag)
  );

  assign alloc_dep_mask = live_q & ~clr_mask;

  logic [PC_W-1:0]  resume_pc;
  logic [PAY_W-1:0] wr_payload;

  assign resume_pc  = alloc_pred_taken ? (alloc_pc + PC_W'(INSN_BYTES)) : alloc_target;
  assign wr_payload = {resume_pc, alloc_map_snap, alloc_fl_snap, alloc_bp_snap,
                       alloc_rob_tail, alloc_lsq_tail};

  // ---------------- checkpoint slots ----------------
  logic [NUM_CKPT*PAY_W-1:0]    ent_payload;
  logic [NUM_CKPT*NUM_CKPT-1:0] ent_parent;

  for (genvar gi = 0; gi < NUM_CKPT; gi++) begin : g_slot
    bcs_entry #(
      .NUM_CKPT (NUM_CKPT),
      .PAY_W    (PAY_W)
    ) slot_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (alloc_tag[gi]),
      .wr_payload (wr_payload),
      .wr_parent  (alloc_dep_mask),
      .clr_en     (bc_clear),
      .clr_mask   (clr_mask),
      .rd_payload (ent_payload[gi*PAY_W +: PAY_W]),
      .rd_parent  (ent_parent[gi*NUM_CKPT +: NUM_CKPT])
    );
  end

  // ---------------- recovery read ----------------
  logic [PAY_W-1:0]    rec_payload;
  logic [NUM_CKPT-1:0] rec_parent;

  bcs_rd_mux #(
    .NUM_CKPT (NUM_CKPT),
    .W        (PAY_W)
  ) pay_mux_i (
    .sel   (rd_sel),
    .words (ent_payload),
    .dout  (rec_payload)
  );

  bcs_rd_mux #(
    .NUM_CKPT (NUM_CKPT),
    .W        (NUM_CKPT)
  ) par_mux_i (
    .sel   (rd_sel),
    .words (ent_parent),
    .dout  (rec_parent)
  );

  assign rec_pc       = rec_payload[PC_LO  +: PC_W];
  assign rec_map      = rec_payload[MAP_LO +: MAP_W];
  assign rec_fl       = rec_payload[FL_LO  +: FL_W];
  assign rec_bp       = rec_payload[BP_LO  +: BP_W];
  assign rec_rob_tail = rec_payload[ROB_LO +: ROB_W];
  assign rec_lsq_tail = rec_payload[LSQ_LO +: LSQ_W];

  // ---------------- live-entry mask ----------------
  always_comb begin
    if (do_squash) live_d = live_q & rec_parent;
    else           live_d = (live_q & ~clr_mask) | alloc_tag;
  end

  assign live_en = do_squash | bc_clear | alloc_grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       live_q <= '0;
    else if (live_en) live_q <= live_d;
  end

  assign live_mask = live_q;

endmodule

// File: rtl/branch_ckpt_stack_chk.sv
module branch_ckpt_stack_chk #(
  parameter int NUM_CKPT = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                alloc_full,
  input logic                alloc_grant,
  input logic [NUM_CKPT-1:0] alloc_tag,
  input logic [NUM_CKPT-1:0] alloc_dep_mask,
  input logic [NUM_CKPT-1:0] live_mask,
  input logic                rslv_valid,
  input logic [NUM_CKPT-1:0] rslv_tag,
  input logic                bc_clear,
  input logic                bc_squash,
  input logic [NUM_CKPT-1:0] bc_tag
);

  p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_full |-> !alloc_grant);

  p_grant_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_grant |-> ($onehot(alloc_tag) && ((alloc_tag & live_mask) == '0)));

  p_grant_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_grant |=> ((live_mask & $past(alloc_tag)) != '0));

  p_dep_drops_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bc_clear |-> ((alloc_dep_mask & bc_tag) == '0));

  p_clear_frees_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bc_clear |=> ((live_mask & $past(bc_tag)) == '0));

  p_squash_shrinks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bc_squash |=> (((live_mask & $past(bc_tag)) == '0) &&
                   ((live_mask & ~$past(live_mask)) == '0)));

  p_squash_drops_alloc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bc_squash |-> !alloc_grant);

  p_bcast_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_clear || bc_squash) |->
      (rslv_valid && !(bc_clear && bc_squash) && $onehot(bc_tag) &&
       (bc_tag == rslv_tag) && ((bc_tag & live_mask) != '0)));

endmodule

bind branch_ckpt_stack branch_ckpt_stack_chk #(.NUM_CKPT(NUM_CKPT)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .alloc_full     (alloc_full),
  .alloc_grant    (alloc_grant),
  .alloc_tag      (alloc_tag),
  .alloc_dep_mask (alloc_dep_mask),
  .live_mask      (live_mask),
  .rslv_valid     (rslv_valid),
  .rslv_tag       (rslv_tag),
  .bc_clear       (bc_clear),
  .bc_squash      (bc_squash),
  .bc_tag         (bc_tag)
);

// File: tb/branch_ckpt_stack_tb_top.sv
module branch_ckpt_stack_tb_top;

  localparam int N      = 4;
  localparam int PC_W   = 32;
  localparam int MAP_W  = 64;
  localparam int FL_W   = 64;
  localparam int BP_W   = 16;
  localparam int ROB_W  = 6;
  localparam int LSQ_W  = 5;
  localparam int STEP   = 4;

  logic             clk;
  logic             rst_n;
  logic             alloc_req, alloc_pred_taken;
  logic [PC_W-1:0]  alloc_pc, alloc_target;
  logic [MAP_W-1:0] alloc_map_snap;
  logic [FL_W-1:0]  alloc_fl_snap;
  logic [BP_W-1:0]  alloc_bp_snap;
  logic [ROB_W-1:0] alloc_rob_tail;
  logic [LSQ_W-1:0] alloc_lsq_tail;
  logic             alloc_full, alloc_grant;
  logic [N-1:0]     alloc_tag, alloc_dep_mask, live_mask;
  logic             rslv_valid, rslv_mispred;
  logic [N-1:0]     rslv_tag;
  logic             bc_clear, bc_squash;
  logic [N-1:0]     bc_tag;
  logic [PC_W-1:0]  rec_pc;
  logic [MAP_W-1:0] rec_map;
  logic [FL_W-1:0]  rec_fl;
  logic [BP_W-1:0]  rec_bp;
  logic [ROB_W-1:0] rec_rob_tail;
  logic [LSQ_W-1:0] rec_lsq_tail;

  branch_ckpt_stack #(
    .NUM_CKPT(N), .PC_W(PC_W), .MAP_W(MAP_W), .FL_W(FL_W),
    .BP_W(BP_W), .ROB_W(ROB_W), .LSQ_W(LSQ_W), .INSN_BYTES(STEP)
  ) dut_i (.*);

  // 50 MHz
  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model: age-ordered list ----------------
  int               age_q[$];
  logic [PC_W-1:0]  m_pc  [N];
  logic [MAP_W-1:0] m_map [N];
  logic [FL_W-1:0]  m_fl  [N];
  logic [BP_W-1:0]  m_bp  [N];
  logic [ROB_W-1:0] m_rob [N];
  logic [LSQ_W-1:0] m_lsq [N];

  logic [N-1:0] e_live;
  logic         e_clear, e_squash, e_grant;
  int           e_rix, e_gix;

  function automatic logic [N-1:0] model_live();
    logic [N-1:0] m = '0;
    foreach (age_q[k]) m[age_q[k]] = 1'b1;
    return m;
  endfunction

  task automatic sample();
    logic hit;
    logic [N-1:0] dep;
    #2;
    e_live = model_live();
    hit = rslv_valid && ($countones(rslv_tag) == 1) && ((rslv_tag & e_live) != '0);
    e_rix = -1;
    for (int i = 0; i < N; i++) if (rslv_tag[i]) e_rix = i;
    e_clear  = hit && !rslv_mispred;
    e_squash = hit && rslv_mispred;
    e_gix = -1;
    for (int i = N - 1; i >= 0; i--) if (!e_live[i]) e_gix = i;
    e_grant = alloc_req && (age_q.size() < N) && !e_squash;
    dep = e_live;
    if (e_clear) dep[e_rix] = 1'b0;

    chk("R2", "live_mask", 64'(live_mask), 64'(e_live));
    chk("R3", "alloc_full", 64'(alloc_full), 64'(age_q.size() == N));
    chk("R2", "alloc_grant", 64'(alloc_grant), 64'(e_grant));
    chk("R2", "alloc_tag", 64'(alloc_tag), e_grant ? (64'd1 << e_gix) : 64'd0);
    chk("R4", "alloc_dep_mask", 64'(alloc_dep_mask), 64'(dep));
    chk("R5", "bc_clear", 64'(bc_clear), 64'(e_clear));
    chk("R6", "bc_squash", 64'(bc_squash), 64'(e_squash));
    chk("R5", "bc_tag", 64'(bc_tag), (e_clear || e_squash) ? 64'(rslv_tag) : 64'd0);
    if (e_squash) begin
      chk("R8", "rec_pc", 64'(rec_pc), 64'(m_pc[e_rix]));
      chk("R7", "rec_map", rec_map, m_map[e_rix]);
      chk("R7", "rec_fl", rec_fl, m_fl[e_rix]);
      chk("R7", "rec_bp", 64'(rec_bp), 64'(m_bp[e_rix]));
      chk("R7", "rec_rob_tail", 64'(rec_rob_tail), 64'(m_rob[e_rix]));
      chk("R7", "rec_lsq_tail", 64'(rec_lsq_tail), 64'(m_lsq[e_rix]));
    end
  endtask

  task automatic advance();
    @(posedge clk);
    if (e_squash) begin
      int p = 0;
      foreach (age_q[k]) if (age_q[k] == e_rix) p = k;
      while (age_q.size() > p) void'(age_q.pop_back());
    end else if (e_clear) begin
      foreach (age_q[k]) if (age_q[k] == e_rix) begin age_q.delete(k); break; end
    end
    if (e_grant) begin
      age_q.push_back(e_gix);
      m_pc[e_gix]  = alloc_pred_taken ? alloc_pc + STEP : alloc_target;
      m_map[e_gix] = alloc_map_snap;
      m_fl[e_gix]  = alloc_fl_snap;
      m_bp[e_gix]  = alloc_bp_snap;
      m_rob[e_gix] = alloc_rob_tail;
      m_lsq[e_gix] = alloc_lsq_tail;
    end
    @(negedge clk);
  endtask

  task automatic set_alloc(input logic req, input logic taken);
    alloc_req        = req;
    alloc_pred_taken = taken;
    alloc_pc         = $urandom & 32'hFFFF_FFFC;
    alloc_target     = $urandom & 32'hFFFF_FFFC;
    alloc_map_snap   = {$urandom, $urandom};
    alloc_fl_snap    = {$urandom, $urandom};
    alloc_bp_snap    = BP_W'($urandom);
    alloc_rob_tail   = ROB_W'($urandom);
    alloc_lsq_tail   = LSQ_W'($urandom);
  endtask

  task automatic set_rslv(input logic v, input logic [N-1:0] t, input logic mis);
    rslv_valid   = v;
    rslv_tag     = t;
    rslv_mispred = mis;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // watchdog
  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    set_alloc(1'b0, 1'b0);
    set_rslv(1'b0, '0, 1'b0);
    repeat (3) @(negedge clk);
    #2;
    chk("R1", "live_mask in reset", 64'(live_mask), 64'd0);
    chk("R1", "alloc_full in reset", 64'(alloc_full), 64'd0);
    chk("R1", "broadcast in reset", 64'({bc_clear, bc_squash}), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    sample();
    chk("R1", "live_mask after reset", 64'(live_mask), 64'd0);
    advance();

    // fill every entry, alternating predicted direction
    for (int k = 0; k < N; k++) begin
      set_alloc(1'b1, k[0]);
      sample();
      advance();
    end
    // full: request must stall
    set_alloc(1'b1, 1'b0);
    sample();
    chk("R3", "grant while full", 64'(alloc_grant), 64'd0);
    advance();
    chk("R3", "live stays full", 64'(live_mask), 64'hF);

    // correct resolve of entry 1 while full
    set_rslv(1'b1, 4'b0010, 1'b0);
    sample();
    chk("R5", "clear raised", 64'(bc_clear), 64'd1);
    advance();
    set_rslv(1'b0, '0, 1'b0);
    set_alloc(1'b1, 1'b1);
    sample();
    chk("R11", "freed entry reused", 64'(alloc_tag), 64'b0010);
    advance();
    set_alloc(1'b0, 1'b0);

    // free entry 3, then resolve it again (not live) and a multi-hot tag
    set_rslv(1'b1, 4'b1000, 1'b0);
    sample();
    advance();
    set_rslv(1'b1, 4'b1000, 1'b1);
    sample();
    chk("R10", "stale tag no squash", 64'(bc_squash), 64'd0);
    advance();
    set_rslv(1'b1, 4'b0011, 1'b0);
    sample();
    chk("R10", "multi-hot no clear", 64'(bc_clear), 64'd0);
    advance();
    sample();
    chk("R10", "live unchanged", 64'(live_mask), 64'b0111);
    set_rslv(1'b0, '0, 1'b0);
    advance();

    // clear entry 0 while allocating entry 3
    set_rslv(1'b1, 4'b0001, 1'b0);
    set_alloc(1'b1, 1'b0);
    sample();
    chk("R4", "dep mask drops resolved bit", 64'(alloc_dep_mask), 64'b0110);
    advance();

    // age order is now 2,1,3: squash 1 with an allocation request
    set_rslv(1'b1, 4'b0010, 1'b1);
    set_alloc(1'b1, 1'b1);
    sample();
    chk("R9", "grant dropped on squash", 64'(alloc_grant), 64'd0);
    chk("R8", "rec_pc taken", 64'(rec_pc), 64'(m_pc[1]));
    advance();
    set_rslv(1'b0, '0, 1'b0);
    sample();
    chk("R6", "younger entries freed", 64'(live_mask), 64'b0100);
    chk("R11", "alloc right after squash", 64'(alloc_tag), 64'b0001);
    advance();

    // randomized mix
    for (int c = 0; c < 2000; c++) begin
      logic [N-1:0] t;
      set_alloc(1'($urandom % 2), 1'($urandom % 2));
      t = N'($urandom);
      if (age_q.size() != 0 && ($urandom % 5) != 0)
        t = N'(1) << age_q[$urandom % age_q.size()];
      set_rslv(($urandom % 3) == 0, t, ($urandom % 4) == 0);
      sample();
      advance();
    end

    summary();
    $finish;
  end

endmodule